// File: doc/BRIEF.md
# On-Chip Extended Data RAM Access Controller

This block sits between a CPU's external-data move instructions and the rest of the data space. For every access it decides whether the access lands in a 1 KB on-chip data RAM, which is mapped at the top of the 64 KB external data space, or goes out on the external bus. It also owns the two special function registers that steer that choice. The first is a page register that supplies the high address byte for accesses through an 8-bit register pointer. The second is a control register that holds the RAM enable and a strobe-mirroring bit.

An access can use a 16-bit pointer or an 8-bit register pointer, and it lasts two cycles, marked by a phase input. The block forms the effective address and raises exactly one of RAM select or external request. It drives the external address and the read and write strobe enables, reads the on-chip array synchronously, and commits writes in the second cycle of the access. A write that was accepted in its first cycle still commits if reset arrives in its second cycle. A reset in the first cycle cancels it. The array has no reset, so its contents are kept through reset.

Top module: `xram_ctrl`

## Requirements
- R1: After reset the page register (SFR address 91h) reads 00h and the control register (SFR address B1h) reads 01h: the RAM is disabled and mirroring is off. Any other SFR address reads 00h.
- R2: A 16-bit pointer access (`mx_wide`=1) selects the on-chip RAM when the RAM is enabled and the pointer is F800h or above. Otherwise it requests the external bus, and `ext_addr` equals the pointer.
- R3: An 8-bit pointer access (`mx_wide`=0) selects the on-chip RAM at address {page, ptr8} when the RAM is enabled and the page is F8h or above. Otherwise it goes external, and `ext_addr` is {port-2 latch, ptr8}.
- R4: An SFR write to the port-2 address A0h also loads the page register with the written byte.
- R5: Clearing bit 0 of the control register enables the RAM. Writing 1 to bit 0 afterwards is ignored, so only a reset disables the RAM. While the RAM is disabled, every access goes external.
- R6: Bit 1 of the control register set makes `strobe_rd` or `strobe_wr` pulse during on-chip RAM accesses as well. External accesses always assert the strobe that matches the direction, whatever bit 1 holds.
- R7: Addresses FC00h–FFFFh are claimed by the RAM when it is enabled, and they alias onto F800h–FBFFh, because address bit 10 is dropped.
- R8: A RAM write is captured in phase 0 and committed at the end of phase 1. Reset during phase 0 leaves the old byte in place. Reset during phase 1 still writes the new byte.
- R9: RAM contents are unchanged by reset.
- R10: Read data for an on-chip read appears on `mx_rdata` in the cycle after phase 0, which is phase 1.
- R11: `ram_sel` and `ext_req` are never high together, and both are low, along with both strobes, when no access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| p2_latch | input | 8 | Current port-2 latch value |
| mx_req | input | 1 | Data move access active (both cycles) |
| mx_phase | input | 1 | 0 = first cycle, 1 = second cycle |
| mx_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register pointer |
| mx_write | input | 1 | 1 = write, 0 = read |
| mx_ptr16 | input | 16 | 16-bit pointer value |
| mx_ptr8 | input | 8 | 8-bit register pointer value |
| mx_wdata | input | 8 | Write data |
| mx_rdata | output | 8 | On-chip RAM read data |
| ram_sel | output | 1 | Access routed to on-chip RAM |
| ext_req | output | 1 | Access routed to external bus |
| ext_addr | output | 16 | External address (zero when not external) |
| strobe_rd | output | 1 | External read strobe enable |
| strobe_wr | output | 1 | External write strobe enable |

## Verification
The assertions check routing exclusivity on every cycle, and the idle state of select and strobes. They also check that the enable never returns to disabled without a reset, that a disabled RAM is never selected, and that external accesses carry their strobe and reset values. Only the bench scenarios show the data side. That covers address aliasing, survival of contents across reset, the one-cycle read latency, and whether a write commits or is dropped depending on which phase the reset arrives in. Each of these needs a write followed by a readback.

// File: rtl/xram_pkg.sv
// Shared constants for the extended data RAM access controller.
// Assumes an 8-bit data path and a 16-bit external data address space.
package xram_pkg;
    localparam int XR_DATA_W   = 8;
    localparam int XR_ADDR_W   = 16;
    localparam int XR_RAM_AW   = 10;
    localparam logic [7:0] XR_BASE_HI  = 8'hF8;
    localparam logic [7:0] XR_SFR_PAGE = 8'h91;
    localparam logic [7:0] XR_SFR_CTRL = 8'hB1;
    localparam logic [7:0] XR_SFR_P2   = 8'hA0;

    // Routing decision produced by the address decoder
    typedef struct packed {
        logic                 ram_sel;
        logic                 ext_req;
        logic [XR_ADDR_W-1:0] ext_addr;
        logic [XR_RAM_AW-1:0] idx;
    } xr_route_t;
endpackage

// File: rtl/xram_sfr.sv
// Page and control special function registers.
// The page register is written at its own address or mirrored from port-2
// writes. The enable bit (bit 0, 1 = disabled) can only be cleared by
// software; reset sets it. Assumes synchronous active-low reset.
module xram_sfr #(
    parameter int         DW        = 8,
    parameter logic [7:0] PAGE_ADDR = 8'h91,
    parameter logic [7:0] CTRL_ADDR = 8'hB1,
    parameter logic [7:0] P2_ADDR   = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] page_o,
    output logic          xram_on_o,
    output logic          mirror_o
);
    logic [DW-1:0] page_q;
    logic          off_q;
    logic          mirror_q;

    // Page register: own address or port-2 shadow write
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (we && (addr == PAGE_ADDR || addr == P2_ADDR))
            page_q <= wdata;
    end

    // Control register: disable bit may only move from 1 to 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= 1'b1;
            mirror_q <= 1'b0;
        end else if (we && addr == CTRL_ADDR) begin
            off_q    <= off_q & wdata[0];
            mirror_q <= wdata[1];
        end
    end

    // Read multiplexer for the two registers
    always_comb begin
        rdata = '0;
        if (addr == PAGE_ADDR)
            rdata = page_q;
        else if (addr == CTRL_ADDR)
            rdata = {{(DW-2){1'b0}}, mirror_q, off_q};
    end

    assign page_o    = page_q;
    assign xram_on_o = ~off_q;
    assign mirror_o  = mirror_q;
endmodule

// File: rtl/xram_route.sv
// Combinational address former and router. It builds the internal address
// from a 16-bit pointer or from {page, ptr8}, decides on-chip versus
// external, and derives the strobe enables. ALIAS_UPPER=1 claims the whole
// top region above the base and folds it onto the array.
module xram_route
    import xram_pkg::*;
#(
    parameter int         AW          = 16,
    parameter int         RAM_AW      = 10,
    parameter logic [7:0] BASE_HI     = 8'hF8,
    parameter bit         ALIAS_UPPER = 1'b1
) (
    input  logic              req,
    input  logic              wide,
    input  logic              write,
    input  logic [AW-1:0]     ptr16,
    input  logic [AW/2-1:0]   ptr8,
    input  logic [AW/2-1:0]   page,
    input  logic [AW/2-1:0]   p2,
    input  logic              xram_on,
    input  logic              mirror,
    output logic              ram_sel,
    output logic              ext_req,
    output logic [AW-1:0]     ext_addr,
    output logic [RAM_AW-1:0] idx,
    output logic              strobe_rd,
    output logic              strobe_wr
);
    localparam int                HW    = AW / 2;
    localparam logic [AW-1:0]     BASE  = {BASE_HI, {HW{1'b0}}};
    localparam logic [AW:0]       LIMIT = {1'b0, BASE} + (AW+1)'(2 ** RAM_AW);

    logic [AW-1:0] form_int;
    logic [AW-1:0] form_ext;
    logic          claim;

    // Internal and external address formation
    always_comb begin
        form_int = wide ? ptr16 : {page, ptr8};
        form_ext = wide ? ptr16 : {p2, ptr8};
    end

    // Region claim: whole upper area or exact window
    generate
        if (ALIAS_UPPER) begin : g_alias
            assign claim = (form_int >= BASE);
        end else begin : g_exact
            assign claim = (form_int >= BASE) && ({1'b0, form_int} < LIMIT);
        end
    endgenerate

    // Final routing and strobe enables
    always_comb begin
        ram_sel   = req && xram_on && claim;
        ext_req   = req && !ram_sel;
        ext_addr  = ext_req ? form_ext : '0;
        idx       = form_int[RAM_AW-1:0];
        strobe_rd = req && !write && (ext_req || mirror);
        strobe_wr = req &&  write && (ext_req || mirror);
    end
endmodule

// File: rtl/xram_commit.sv
// On-chip array with two-phase write commit and registered read.
// Phase 0 captures a write only when out of reset; phase 1 commits a
// captured write even if reset is asserted then. The array is not reset.
module xram_commit #(
    parameter int DW     = 8,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              phase,
    input  logic              write,
    input  logic              ram_sel,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 2 ** RAM_AW;

    logic [DW-1:0]     mem [DEPTH];
    logic              pend_v;
    logic [RAM_AW-1:0] pend_idx;
    logic [DW-1:0]     pend_data;
    logic              cap;

    assign cap = req && !phase && write && ram_sel;

    // Capture a write in phase 0; reset in this cycle cancels it
    always_ff @(posedge clk) begin
        pend_v <= rst_n && cap;
        if (cap) begin
            pend_idx  <= idx;
            pend_data <= wdata;
        end
    end

    // Commit in phase 1 regardless of reset
    always_ff @(posedge clk) begin
        if (pend_v && req && phase)
            mem[pend_idx] <= pend_data;
    end

    // Registered read launched in phase 0
    always_ff @(posedge clk) begin
        if (req && !phase && !write && ram_sel)
            rdata <= mem[idx];
    end
endmodule

// File: rtl/xram_ctrl.sv
// Top of the extended data RAM access controller: SFR bank, router and
// array with phase-aware write commit. Inputs are held for both cycles of
// an access; mx_phase marks the cycle.
module xram_ctrl
    import xram_pkg::*;
#(
    parameter int         DW          = XR_DATA_W,
    parameter int         AW          = XR_ADDR_W,
    parameter int         RAM_AW      = XR_RAM_AW,
    parameter logic [7:0] BASE_HI     = XR_BASE_HI,
    parameter bit         ALIAS_UPPER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sfr_we,
    input  logic [7:0]    sfr_addr,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] sfr_rdata,
    input  logic [7:0]    p2_latch,
    input  logic          mx_req,
    input  logic          mx_phase,
    input  logic          mx_wide,
    input  logic          mx_write,
    input  logic [AW-1:0] mx_ptr16,
    input  logic [7:0]    mx_ptr8,
    input  logic [DW-1:0] mx_wdata,
    output logic [DW-1:0] mx_rdata,
    output logic          ram_sel,
    output logic          ext_req,
    output logic [AW-1:0] ext_addr,
    output logic          strobe_rd,
    output logic          strobe_wr
);
    logic [DW-1:0] page;
    logic          xram_on;
    logic          mirror;
    xr_route_t     rt;

    xram_sfr #(
        .DW(DW), .PAGE_ADDR(XR_SFR_PAGE), .CTRL_ADDR(XR_SFR_CTRL), .P2_ADDR(XR_SFR_P2)
    ) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
        .rdata(sfr_rdata), .page_o(page), .xram_on_o(xram_on), .mirror_o(mirror)
    );

    xram_route #(
        .AW(AW), .RAM_AW(RAM_AW), .BASE_HI(BASE_HI), .ALIAS_UPPER(ALIAS_UPPER)
    ) u_route (
        .req(mx_req), .wide(mx_wide), .write(mx_write), .ptr16(mx_ptr16),
        .ptr8(mx_ptr8), .page(page), .p2(p2_latch), .xram_on(xram_on),
        .mirror(mirror), .ram_sel(rt.ram_sel), .ext_req(rt.ext_req),
        .ext_addr(rt.ext_addr), .idx(rt.idx), .strobe_rd(strobe_rd),
        .strobe_wr(strobe_wr)
    );

    xram_commit #(.DW(DW), .RAM_AW(RAM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .req(mx_req), .phase(mx_phase),
        .write(mx_write), .ram_sel(rt.ram_sel), .idx(rt.idx),
        .wdata(mx_wdata), .rdata(mx_rdata)
    );

    assign ram_sel  = rt.ram_sel;
    assign ext_req  = rt.ext_req;
    assign ext_addr = rt.ext_addr;
endmodule

// File: rtl/xram_ctrl_chk.sv
// Property checker for xram_ctrl, attached by bind.
module xram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mx_req,
    input logic       mx_write,
    input logic       ram_sel,
    input logic       ext_req,
    input logic       strobe_rd,
    input logic       strobe_wr,
    input logic       xram_on,
    input logic [7:0] page
);
    // R11: one destination at most
    assert_route_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && ext_req));
    // R11: quiet when idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mx_req |-> (!ram_sel && !ext_req && !strobe_rd && !strobe_wr));
    // R5: enable is sticky until reset
    assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(xram_on)) |-> xram_on);
    // R5: disabled RAM is never selected
    assert_disabled_external_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xram_on |-> !ram_sel);
    // R6: external reads carry the read strobe
    assert_ext_read_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !mx_write) |-> (strobe_rd && !strobe_wr));
    // R6: external writes carry the write strobe
    assert_ext_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && mx_write) |-> (strobe_wr && !strobe_rd));
    // R1: register state right after reset release
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (page == 8'h00 && !xram_on));
endmodule

bind xram_ctrl xram_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mx_req(mx_req), .mx_write(mx_write),
    .ram_sel(ram_sel), .ext_req(ext_req), .strobe_rd(strobe_rd),
    .strobe_wr(strobe_wr), .xram_on(xram_on), .page(page)
);

// File: tb/xram_ctrl_bench.sv
module xram_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [7:0]  p2_latch = 8'h00;
    logic        mx_req = 1'b0, mx_phase = 1'b0, mx_wide = 1'b0, mx_write = 1'b0;
    logic [15:0] mx_ptr16 = 16'h0;
    logic [7:0]  mx_ptr8 = 8'h0, mx_wdata = 8'h0;
    logic [7:0]  mx_rdata;
    logic        ram_sel, ext_req, strobe_rd, strobe_wr;
    logic [15:0] ext_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    xram_ctrl u_xram_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .p2_latch(p2_latch),
        .mx_req(mx_req), .mx_phase(mx_phase), .mx_wide(mx_wide),
        .mx_write(mx_write), .mx_ptr16(mx_ptr16), .mx_ptr8(mx_ptr8),
        .mx_wdata(mx_wdata), .mx_rdata(mx_rdata), .ram_sel(ram_sel),
        .ext_req(ext_req), .ext_addr(ext_addr), .strobe_rd(strobe_rd),
        .strobe_wr(strobe_wr)
    );

    // Monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = {8'h00, mx_rdata};
                    1: act = {8'h00, sfr_rdata};
                    2: act = {12'h000, ram_sel, ext_req, strobe_rd, strobe_wr};
                    default: act = ext_addr;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(int sel, logic [15:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic fire();
        ->sample_ev;
        #1;
    endtask

    task automatic sfr_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_check(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        sfr_addr = a;
        #1;
        expect_item(1, {8'h00, exp}, tag);
        fire();
    endtask

    task automatic set_access(bit wide, logic [15:0] p16, logic [7:0] p8, bit wr, logic [7:0] d);
        mx_req = 1'b1; mx_phase = 1'b0; mx_wide = wide; mx_write = wr;
        mx_ptr16 = p16; mx_ptr8 = p8; mx_wdata = d;
    endtask

    // route code is {ram_sel, ext_req, strobe_rd, strobe_wr}
    task automatic route_check(bit wide, logic [15:0] p16, logic [7:0] p8, bit wr,
                               logic [3:0] code, logic [15:0] eaddr, string tag);
        @(negedge clk);
        set_access(wide, p16, p8, wr, 8'h00);
        #1;
        expect_item(2, {12'h000, code}, tag);
        expect_item(3, eaddr, tag);
        fire();
        @(negedge clk);
        mx_phase = 1'b1;
        @(negedge clk);
        mx_req = 1'b0; mx_phase = 1'b0;
    endtask

    // rst_ph: 0 none, 1 reset in first cycle, 2 reset in second cycle
    task automatic mem_write(bit wide, logic [15:0] p16, logic [7:0] p8, logic [7:0] d, int rst_ph);
        @(negedge clk);
        set_access(wide, p16, p8, 1'b1, d);
        rst_n = (rst_ph == 1) ? 1'b0 : 1'b1;
        @(negedge clk);
        mx_phase = 1'b1;
        rst_n = (rst_ph == 2) ? 1'b0 : 1'b1;
        @(negedge clk);
        mx_req = 1'b0; mx_phase = 1'b0; mx_write = 1'b0; rst_n = 1'b1;
    endtask

    task automatic mem_read(bit wide, logic [15:0] p16, logic [7:0] p8, logic [7:0] exp, string tag);
        @(negedge clk);
        set_access(wide, p16, p8, 1'b0, 8'h00);
        @(negedge clk);
        mx_phase = 1'b1;
        #1;
        expect_item(0, {8'h00, exp}, tag);
        fire();
        @(negedge clk);
        mx_req = 1'b0; mx_phase = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        sfr_check(8'h91, 8'h00, "R1 page reset");
        sfr_check(8'hB1, 8'h01, "R1 ctrl reset");
        sfr_check(8'h80, 8'h00, "R1 other address");
        route_check(1, 16'hF900, 8'h00, 0, 4'b0110, 16'hF900, "R5 disabled goes external");
        // R5 enable
        sfr_write(8'hB1, 8'h00);
        sfr_check(8'hB1, 8'h00, "R5 enabled");
        // R2 wide routing
        route_check(1, 16'hF900, 8'h00, 0, 4'b1000, 16'h0000, "R2 wide internal");
        route_check(1, 16'hF7FF, 8'h00, 0, 4'b0110, 16'hF7FF, "R2 wide below base");
        // R3 narrow routing
        p2_latch = 8'h12;
        route_check(0, 16'h0000, 8'h34, 0, 4'b0110, 16'h1234, "R3 narrow low page external");
        sfr_write(8'h91, 8'hF9);
        route_check(0, 16'h0000, 8'h10, 0, 4'b1000, 16'h0000, "R3 narrow high page internal");
        // R4 port-2 write mirrors into page
        sfr_write(8'hA0, 8'hF8);
        sfr_check(8'h91, 8'hF8, "R4 page follows port-2 write");
        // R6 strobe mirroring
        sfr_write(8'hB1, 8'h02);
        sfr_check(8'hB1, 8'h02, "R6 mirror bit set");
        route_check(1, 16'hF900, 8'h00, 0, 4'b1010, 16'h0000, "R6 mirrored read strobe");
        route_check(1, 16'hF900, 8'h00, 1, 4'b1001, 16'h0000, "R6 mirrored write strobe");
        route_check(1, 16'h1000, 8'h00, 1, 4'b0101, 16'h1000, "R6 external write unchanged");
        sfr_write(8'hB1, 8'h00);
        route_check(1, 16'hF900, 8'h00, 1, 4'b1000, 16'h0000, "R6 mirror off no strobe");
        // R5 disable attempt ignored
        sfr_write(8'hB1, 8'h01);
        sfr_check(8'hB1, 8'h00, "R5 disable write ignored");
        route_check(1, 16'hF900, 8'h00, 0, 4'b1000, 16'h0000, "R5 still internal");
        // R10 read latency and R3 narrow data path
        mem_write(1, 16'hF900, 8'h00, 8'hA5, 0);
        mem_read(1, 16'hF900, 8'h00, 8'hA5, "R10 wide read back");
        sfr_write(8'h91, 8'hF9);
        mem_read(0, 16'h0000, 8'h00, 8'hA5, "R3 narrow read same byte");
        // R7 alias
        mem_write(1, 16'hFD23, 8'h00, 8'h3C, 0);
        mem_read(1, 16'hF923, 8'h00, 8'h3C, "R7 alias onto lower window");
        route_check(1, 16'hFFFF, 8'h00, 0, 4'b1000, 16'h0000, "R7 top address claimed");
        // R8 reset-phase write commit
        mem_write(1, 16'hF950, 8'h00, 8'h11, 0);
        mem_write(1, 16'hF950, 8'h00, 8'h22, 1);
        sfr_check(8'hB1, 8'h01, "R1 ctrl after mid-access reset");
        sfr_write(8'hB1, 8'h00);
        mem_read(1, 16'hF950, 8'h00, 8'h11, "R8 reset in first cycle keeps old");
        mem_write(1, 16'hF950, 8'h00, 8'h33, 2);
        sfr_write(8'hB1, 8'h00);
        mem_read(1, 16'hF950, 8'h00, 8'h33, "R8 reset in second cycle writes new");
        // R9 contents survive reset
        mem_read(1, 16'hF900, 8'h00, 8'hA5, "R9 contents after reset");
        // R11 idle
        @(negedge clk);
        #1;
        expect_item(2, 16'h0000, "R11 idle quiet");
        fire();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule